// File: doc/BRIEF.md
# SMBus Byte-Register Target

This block is a serial-bus target that gives a host byte-wide access to a small bank of slot-control and status registers. It handles three transfers: a byte write (address with write direction, command byte, data byte), a byte read (address with write direction and command byte, then a repeated START, address with read direction and one returned byte), and a bare receive (address with read direction, then the byte at the last command). The command byte is kept in a pointer that survives from one transfer to the next, so a bare receive returns the register named last. The device address is `1000` followed by three strap pins. The straps are captured only while reset is held, so up to eight targets can share one bus.

SCL and SDA go through a two-stage synchronizer. Edges, START and STOP are detected on the system clock. SDA is driven only by pulling it low, and `sda_oe` is the pull-down enable. Inside there are eight locations. Slot A control is at 02h, slot B control at 03h, slot A status at 04h, slot B status at 05h and common status at 06h. Every other command value is reserved. The slot-control logic reads and writes the defined locations through a separate port, and it sees the two control bytes directly.

The transfer engine has these states:
- IDLE: waiting for a START.
- ADDR: shifting in the address byte.
- ADDR_ACK: pulling SDA low to acknowledge the address.
- CMD and CMD_ACK: taking in the command byte and acknowledging it.
- WDATA and WDATA_ACK: taking in a data byte and acknowledging it.
- RDATA: shifting a byte out.
- RD_ACK: sampling the host's acknowledge.
- IGNORE: staying silent until the next START or STOP.

Its transitions are:
- IDLE→ADDR on START.
- ADDR→ADDR_ACK when the address matches, and ADDR→IGNORE when it does not.
- ADDR_ACK→CMD for a write direction, and ADDR_ACK→RDATA for a read direction.
- CMD→CMD_ACK, then CMD_ACK→WDATA.
- WDATA→WDATA_ACK, then WDATA_ACK→WDATA.
- RDATA→RD_ACK.
- RD_ACK→RDATA when the host acknowledges, and RD_ACK→IGNORE when it does not.
- Any state→ADDR on START.
- Any state→IDLE on STOP.

Top module: `smb_regslave`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `1000` followed by `strap[2:0]`, with `strap[2]` as the most significant of the three. Bit 0 of the address byte selects the direction: 0 is write and 1 is read. A mismatched address gets no acknowledge.
- R2: `strap` is captured only while `rst_n` is low. Later changes on `strap` do not alter the address the target answers to.
- R3: In a byte write, the command byte and the data byte are each acknowledged. The data byte is stored at the command location when that location is 02h–06h. Location 02h appears on `ctl_a` and location 03h on `ctl_b`.
- R4: A byte read returns the content of the location named by the command byte, most significant bit first.
- R5: The command pointer is kept between transfers, so a bare receive returns the location named by the last command byte. After reset the pointer is 00h.
- R6: Command values 00h, 01h, 07h and every value from 08h upward are reserved. Writes to them are acknowledged and discarded, and reads of them return FFh.
- R7: After reset, locations 02h to 06h hold 00h and `sda_oe` is low.
- R8: When the host acknowledges a returned byte, the same location is sent again, because there is no auto-increment. When the host does not acknowledge, SDA stays released until the next START or STOP.
- R9: A START at any point, including in the middle of a byte, begins a new address phase. A STOP returns the target to idle.
- R10: When `sl_we` is high, `sl_wdata` is written to location `sl_addr` if that location is 02h–06h. The write is ignored for any other location. `sl_rdata` shows the content of `sl_addr`, and FFh for a reserved location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset; straps are captured while it is low |
| strap | input | 3 | Low three bits of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls the data line low |
| sl_we | input | 1 | Slot-side write strobe |
| sl_addr | input | 3 | Slot-side location select |
| sl_wdata | input | 8 | Slot-side write data |
| sl_rdata | output | 8 | Content of the location at `sl_addr` |
| ctl_a | output | 8 | Slot A control byte (location 02h) |
| ctl_b | output | 8 | Slot B control byte (location 03h) |

## Verification
A bare receive straight after reset must return FFh, because the pointer starts at the reserved 00h. A design that kept a stale pointer, or that gave reserved reads a default of 00h, would show a different byte. The bench changes the straps after reset and then addresses both the old and the new address. A design that kept sampling the straps would answer the new address and ignore the old one. A two-byte read with a host acknowledge checks that the same register repeats and that SDA is free once the host stops acknowledging. An engine that incremented the pointer or kept driving the line would corrupt the second byte or the STOP. A START issued in the middle of a command byte must restart address decoding. A design that waited for the byte to finish would write the wrong location.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int DATA_W = 8;
    localparam logic [3:0] DEV_ADDR_HI = 4'b1000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_ff[SYNC_STAGES-1];
            sda_q  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_ff[SYNC_STAGES-1];
    assign sda_s     = sda_ff[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // data line moving while the clock line stays high marks a bus condition
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int LOC_AW = 3,
    parameter int W      = 8,
    parameter int DEF_LO = 2,
    parameter int DEF_HI = 6,
    parameter int CTL_A  = 2,
    parameter int CTL_B  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              sl_we,
    input  logic [LOC_AW-1:0] sl_addr,
    input  logic [W-1:0]      sl_wdata,
    output logic [W-1:0]      sl_rdata,
    output logic [W-1:0]      ctl_a,
    output logic [W-1:0]      ctl_b
);
    localparam int NUM_LOC = 1 << LOC_AW;

    logic [W-1:0] loc [NUM_LOC];
    logic         bus_in_range;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        if (g >= DEF_LO && g <= DEF_HI) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    loc[g] <= '0;
                else if (sl_we && sl_addr == LOC_AW'(g))
                    loc[g] <= sl_wdata;   // slot side wins a same-cycle clash
                else if (bus_we && bus_addr == 8'(g))
                    loc[g] <= bus_wdata;
            end
        end else begin : g_rsv
            assign loc[g] = '1;
        end
    end

    assign bus_in_range = bus_addr < 8'(NUM_LOC);
    assign bus_rdata    = bus_in_range ? loc[bus_addr[LOC_AW-1:0]] : '1;
    assign sl_rdata     = loc[sl_addr];
    assign ctl_a        = loc[CTL_A];
    assign ctl_b        = loc[CTL_B];

    logic bus_def, sl_def;
    assign bus_def = (bus_addr >= 8'(DEF_LO)) && (bus_addr <= 8'(DEF_HI));
    assign sl_def  = (int'(sl_addr) >= DEF_LO) && (int'(sl_addr) <= DEF_HI);

    // R3: a host write to a defined location lands there one cycle later
    assert_bus_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_def && !(sl_we && sl_addr == bus_addr[LOC_AW-1:0]))
        |=> loc[$past(bus_addr[LOC_AW-1:0])] == $past(bus_wdata));

    // R10: a slot-side write to a defined location lands there
    assert_slot_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_we && sl_def) |=> loc[$past(sl_addr)] == $past(sl_wdata));
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [7:0]        ptr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

    smb_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DATA_W-1:0] rx_q, rx_d, tx_q, tx_d;
    logic [7:0]        ptr_q, ptr_d;
    logic              rw_q, rw_d, nack_q, nack_d, wr_q, wr_d;
    logic [6:0]        dev_addr_q;

    // straps are captured only while the power-up reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) dev_addr_q <= {DEV_ADDR_HI, strap};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '1;
            ptr_q  <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            rx_q   <= rx_d;
            tx_q   <= tx_d;
            ptr_q  <= ptr_d;
            rw_q   <= rw_d;
            nack_q <= nack_d;
            wr_q   <= wr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        rx_d    = rx_q;
        tx_d    = tx_q;
        ptr_d   = ptr_q;
        rw_d    = rw_q;
        nack_d  = nack_q;
        wr_d    = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: ;
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && cnt_q < FULL) begin
                        rx_d  = {rx_q[DATA_W-2:0], sda_s};
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == FULL) begin
                        if (state_q == ST_ADDR) begin
                            rw_d    = rx_q[0];
                            state_d = (rx_q[7:1] == dev_addr_q) ? ST_ADDR_ACK : ST_IGNORE;
                        end else if (state_q == ST_CMD) begin
                            ptr_d   = rx_q;
                            state_d = ST_CMD_ACK;
                        end else begin
                            wr_d    = 1'b1;
                            state_d = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw_q) begin
                            tx_d    = rd_data;
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        cnt_d   = '0;
                        state_d = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == FULL) state_d = ST_RD_ACK;
                        else               tx_d = {tx_q[DATA_W-2:0], 1'b1};
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        nack_d = sda_s;
                    end else if (scl_fall) begin
                        if (nack_q) begin
                            state_d = ST_IGNORE;
                        end else begin
                            tx_d    = rd_data;
                            cnt_d   = '0;
                            state_d = ST_RDATA;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_q[DATA_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

    assign wr_en   = wr_q;
    assign ptr     = ptr_q;
    assign wr_data = rx_q;

    // R1: the acknowledge phase is entered only for our own address
    assert_addr_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |-> rx_q[7:1] == dev_addr_q);

    // R2: the captured address never moves once out of reset
    assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(dev_addr_q));

    // R9: a detected START always lands in the address phase
    assert_start_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(start_det)) |-> state_q == ST_ADDR);

    // R8: a returned byte is resent only after a host acknowledge
    assert_resend_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && $past(state_q) == ST_RD_ACK) |-> !$past(nack_q));

    // R3: the store strobe is issued only while acknowledging a data byte
    assert_store_in_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> state_q == ST_WDATA_ACK);
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave #(
    parameter int LOC_AW      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              sl_we,
    input  logic [LOC_AW-1:0] sl_addr,
    input  logic [7:0]        sl_wdata,
    output logic [7:0]        sl_rdata,
    output logic [7:0]        ctl_a,
    output logic [7:0]        ctl_b
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en;
    logic [7:0] ptr, wr_data, rd_data;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .strap(strap), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
        .ptr(ptr), .wr_data(wr_data)
    );

    smb_regfile #(.LOC_AW(LOC_AW), .W(8)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(wr_en), .bus_addr(ptr), .bus_wdata(wr_data), .bus_rdata(rd_data),
        .sl_we(sl_we), .sl_addr(sl_addr), .sl_wdata(sl_wdata), .sl_rdata(sl_rdata),
        .ctl_a(ctl_a), .ctl_b(ctl_b)
    );
endmodule

// File: tb/smb_regslave_bench.sv
module smb_regslave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [7:0] AW = 8'h8A;   // strap 101 -> 1000101, write
    localparam logic [7:0] AR = 8'h8B;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] strap = 3'b101;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sl_we = 1'b0;
    logic [2:0] sl_addr = 3'd0;
    logic [7:0] sl_wdata = 8'h00;
    logic sda_oe;
    logic [7:0] sl_rdata, ctl_a, ctl_b;
    wire sda_line = sda_m & ~sda_oe;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_regslave u_smb_regslave (
        .clk(clk), .rst_n(rst_n), .strap(strap), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .sl_we(sl_we), .sl_addr(sl_addr), .sl_wdata(sl_wdata),
        .sl_rdata(sl_rdata), .ctl_a(ctl_a), .ctl_b(ctl_b)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq; repeat (Q) @(negedge clk); endtask

    task automatic m_start;
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
    endtask

    task automatic m_tx(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
        end
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; ack = ~sda_line; wq; scl_m = 1'b0; wq;
    endtask

    task automatic m_rx(output logic [7:0] b, input logic mack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq; scl_m = 1'b1; wq; b[i] = sda_line; wq; scl_m = 1'b0;
        end
        wq; sda_m = ~mack; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq; sda_m = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] adr, input logic [7:0] cmd,
                             input logic [7:0] dat, output logic ok);
        logic a0, a1, a2;
        m_start; m_tx(adr, a0);
        if (!a0) begin m_stop; ok = 1'b0; return; end
        m_tx(cmd, a1); m_tx(dat, a2); m_stop;
        ok = a1 & a2;
    endtask

    task automatic bus_read(input logic [7:0] cmd, output logic [7:0] dat);
        logic a;
        m_start; m_tx(AW, a); m_tx(cmd, a);
        m_start; m_tx(AR, a); m_rx(dat, 1'b0); m_stop;
    endtask

    task automatic bus_recv(output logic [7:0] dat);
        logic a;
        m_start; m_tx(AR, a); m_rx(dat, 1'b0); m_stop;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R7 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
        chk("R7 ctl_a reset", ctl_a, 8'h00);
        chk("R7 ctl_b reset", ctl_b, 8'h00);
        for (int i = 4; i <= 6; i++) begin
            sl_addr = 3'(i); @(negedge clk);
            chk("R7 status reset", sl_rdata, 8'h00);
        end
        bus_recv(d);
        chk("R5 pointer resets to reserved 00h", d, 8'hFF);
    endtask

    task automatic t_write_read;
        logic ok; logic [7:0] d;
        bus_write(AW, 8'h02, 8'hA5, ok);
        chk("R1 R3 write acked", {7'd0, ok}, 8'h01);
        chk("R3 ctl_a updated", ctl_a, 8'hA5);
        bus_write(AW, 8'h03, 8'h3C, ok);
        chk("R3 ctl_b updated", ctl_b, 8'h3C);
        bus_read(8'h02, d);
        chk("R4 read 02h", d, 8'hA5);
        bus_read(8'h03, d);
        chk("R4 read 03h", d, 8'h3C);
    endtask

    task automatic t_receive;
        logic ok; logic [7:0] d;
        bus_write(AW, 8'h05, 8'h96, ok);
        bus_recv(d);
        chk("R5 receive uses last command", d, 8'h96);
        bus_recv(d);
        chk("R5 pointer persists", d, 8'h96);
    endtask

    task automatic t_address;
        logic ok;
        bus_write(8'h8C, 8'h02, 8'h11, ok);
        chk("R1 foreign address not acked", {7'd0, ok}, 8'h00);
        chk("R1 foreign write no effect", ctl_a, 8'hA5);
        strap = 3'b000;
        bus_write(8'h80, 8'h02, 8'h22, ok);
        chk("R2 new strap value ignored", {7'd0, ok}, 8'h00);
        bus_write(AW, 8'h02, 8'h5A, ok);
        chk("R2 captured address still answers", {7'd0, ok}, 8'h01);
        chk("R2 write via captured address", ctl_a, 8'h5A);
        strap = 3'b101;
    endtask

    task automatic t_reserved;
        logic ok; logic [7:0] d;
        bus_write(AW, 8'h07, 8'h00, ok);
        chk("R6 reserved write acked", {7'd0, ok}, 8'h01);
        bus_read(8'h07, d);
        chk("R6 reserved 07h reads FF", d, 8'hFF);
        bus_write(AW, 8'h42, 8'h00, ok);
        chk("R6 high command write acked", {7'd0, ok}, 8'h01);
        chk("R6 aliased write discarded", ctl_a, 8'h5A);
        bus_read(8'h42, d);
        chk("R6 high command reads FF", d, 8'hFF);
        bus_read(8'h01, d);
        chk("R6 reserved 01h reads FF", d, 8'hFF);
    endtask

    task automatic t_slot_port;
        logic ok; logic [7:0] d;
        sl_addr = 3'd4; sl_wdata = 8'hC3; sl_we = 1'b1; @(negedge clk); sl_we = 1'b0;
        bus_read(8'h04, d);
        chk("R10 slot write seen by host", d, 8'hC3);
        bus_write(AW, 8'h06, 8'h81, ok);
        sl_addr = 3'd6; @(negedge clk);
        chk("R10 host write seen by slot", sl_rdata, 8'h81);
        sl_addr = 3'd1; sl_wdata = 8'h12; sl_we = 1'b1; @(negedge clk); sl_we = 1'b0;
        @(negedge clk);
        chk("R10 slot write to reserved ignored", sl_rdata, 8'hFF);
    endtask

    task automatic t_multi_read;
        logic a; logic [7:0] d1, d2;
        m_start; m_tx(AW, a); m_tx(8'h03, a);
        m_start; m_tx(AR, a); m_rx(d1, 1'b1); m_rx(d2, 1'b0);
        chk("R8 first byte", d1, 8'h3C);
        chk("R8 repeated byte after ack", d2, 8'h3C);
        wq; wq;
        chk("R8 line released after nack", {7'd0, sda_oe}, 8'h00);
        m_stop;
    endtask

    task automatic t_abort;
        logic a, ok; logic [7:0] d;
        m_start; m_tx(AW, a);
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b0; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
        end
        m_start; m_tx(AW, a); m_tx(8'h02, ok); m_tx(8'h77, a); m_stop;
        chk("R9 restart mid-byte acked", {7'd0, a & ok}, 8'h01);
        chk("R9 write after restart", ctl_a, 8'h77);
        bus_read(8'h02, d);
        chk("R9 idle after stop then read", d, 8'h77);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_write_read;
        t_receive;
        t_address;
        t_reserved;
        t_slot_port;
        t_multi_read;
        t_abort;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule